// File: doc/BRIEF.md
# Supervisor Timer Compare Unit with Privilege Gating

This block keeps two 64-bit timer compare registers, one for the supervisor level and one for the virtual-supervisor level, and turns them into two level-sensitive timer-pending outputs. The supervisor comparison uses the incoming time value as it is. The virtual comparison adds a hypervisor time offset to that value first, and the sum wraps modulo 2^64.

The block also serves register read and write requests aimed at the two compare registers. The response is combinational and appears in the same cycle as the request. Each request is judged on four things: the current privilege level, the virtualization bit, the machine-level counter-enable timer bit and the hypervisor-level counter-enable timer bit. The outcome is one of the following:

- the access is granted, and a read returns the register value while a write takes effect at the next clock edge;
- an illegal-instruction fault is raised;
- a virtual-instruction fault is raised.

A virtualized supervisor that accesses the supervisor compare address is steered to the virtual compare register. The time counter, trap delivery and every other register are outside this block.

Top module: `tcmp_top`

## Requirements
- R1: After synchronous reset, both compare registers hold all ones. With time below 2^64-1, both pending outputs are 0.
- R2: `stip_o` is 1 exactly when `time_i` >= the supervisor compare, as an unsigned 64-bit compare. It is a level output. It follows a granted write from the cycle after the write edge, and it follows changes of `time_i` at once.
- R3: `vstip_o` is 1 exactly when (`time_i` + `htimedelta_i`) mod 2^64 >= the virtual compare, as an unsigned compare.
- R4: Privilege encoding on `priv_i` is 0 for user, 1 for supervisor, 2 reserved and 3 for machine. At level 3 an access is always granted, whatever the enable bits and `virt_i`. Address 12'h14D selects the supervisor compare and address 12'h24D selects the virtual compare.
- R5: When `mcnt_tm_i` is 0, an access to either address from any level other than 3 raises `rsp_illegal_o`.
- R6: At level 1 with `virt_i`=0 and `mcnt_tm_i`=1, address 12'h14D reaches the supervisor compare and address 12'h24D reaches the virtual compare.
- R7: At level 1 with `virt_i`=1 and `mcnt_tm_i`=1, address 12'h14D reaches the virtual compare when `hcnt_tm_i`=1 and raises `rsp_virtual_o` when `hcnt_tm_i`=0. Address 12'h24D at this level raises `rsp_virtual_o`.
- R8: Level 0 with `virt_i`=0, and level 2, always raise `rsp_illegal_o`. Level 0 with `virt_i`=1 raises `rsp_virtual_o` when `mcnt_tm_i`=1 and `rsp_illegal_o` otherwise.
- R9: A faulting request returns zero read data and leaves both compare registers unchanged. At most one fault flag is set at a time.
- R10: A request to any other address raises no fault, returns zero data and changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Free-running time value |
| htimedelta_i | input | 64 | Offset added to time for the virtual comparison |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 2 reserved, 3 M) |
| virt_i | input | 1 | Virtualization mode bit |
| mcnt_tm_i | input | 1 | Machine-level counter-enable timer bit |
| hcnt_tm_i | input | 1 | Hypervisor-level counter-enable timer bit |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 12 | Register address |
| req_wdata_i | input | 64 | Write data |
| rsp_rdata_o | output | 64 | Read data, zero on fault or miss |
| rsp_illegal_o | output | 1 | Illegal-instruction fault |
| rsp_virtual_o | output | 1 | Virtual-instruction fault |
| stip_o | output | 1 | Supervisor timer pending |
| vstip_o | output | 1 | Virtual-supervisor timer pending |

## Verification
The bench walks every combination of privilege level, virtualization bit and enable bits on both addresses. A design that checked the hypervisor gate before the machine gate would report a virtual fault where an illegal one belongs. A design without redirection would let a virtualized supervisor read the supervisor register. The offset sum is driven across the 2^64 wrap, where a compare carried out at 65 bits would raise the virtual pending bit wrongly, and compare values with the top bit set catch a signed comparison. Faulting writes and misses are followed by machine-level read-back, which exposes a write enable that ignores the fault.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SUP  = 2'd1,
        TGT_VIRT = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic illegal;
        logic virt_fault;
    } verdict_t;

    localparam int NUM_CMP  = 2;
    localparam int IDX_SUP  = 0;
    localparam int IDX_VIRT = 1;

    // Machine gate first, then mode-specific checks, then the hypervisor gate.
    function automatic verdict_t judge(priv_e priv, logic v, logic mtm,
                                       logic htm, logic hit_s, logic hit_vs);
        verdict_t r;
        r = '{tgt: TGT_NONE, illegal: 1'b0, virt_fault: 1'b0};
        if (hit_s || hit_vs) begin
            if (priv == PRIV_M) begin
                r.tgt = hit_s ? TGT_SUP : TGT_VIRT;
            end else if (!mtm || priv == PRIV_RSV || (priv == PRIV_U && !v)) begin
                r.illegal = 1'b1;
            end else if (v) begin
                if (priv == PRIV_S && hit_s && htm) r.tgt = TGT_VIRT;
                else                                r.virt_fault = 1'b1;
            end else begin
                r.tgt = hit_s ? TGT_SUP : TGT_VIRT;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tcmp_access.sv
module tcmp_access
    import tcmp_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] S_ADDR  = 12'h14D,
    parameter logic [11:0] VS_ADDR = 12'h24D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic              mtm,
    input  logic              htm,
    output verdict_t          verdict
);

    logic hit_s, hit_vs;

    always_comb begin
        hit_s   = valid && (addr == ADDR_W'(S_ADDR));
        hit_vs  = valid && (addr == ADDR_W'(VS_ADDR));
        verdict = judge(priv_e'(priv), virt, mtm, htm, hit_s, hit_vs);
    end

    // R9: a request ends in at most one of grant, illegal fault, virtual fault
    a_r9_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({verdict.illegal, verdict.virt_fault, verdict.tgt != TGT_NONE}));

    // R4: machine level is never faulted
    a_r4_machine_granted: assert property (@(posedge clk) disable iff (rst)
        (priv == 2'd3) |-> !(verdict.illegal || verdict.virt_fault));

endmodule

// File: rtl/tcmp_cmp_reg.sv
module tcmp_cmp_reg #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] time_eff,
    output logic [WIDTH-1:0] value,
    output logic             pending
);

    always_ff @(posedge clk) begin
        if (rst)     value <= '1;
        else if (we) value <= wdata;
    end

    assign pending = (time_eff >= value);

    // R1: register comes out of reset as all ones
    a_r1_reset_ones: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (value == '1));

    // R2: a granted write lands on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (value == $past(wdata)));

endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
    import tcmp_pkg::*;
#(
    parameter int          WIDTH   = 64,
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] S_ADDR  = 12'h14D,
    parameter logic [11:0] VS_ADDR = 12'h24D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  time_i,
    input  logic [WIDTH-1:0]  htimedelta_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              mcnt_tm_i,
    input  logic              hcnt_tm_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [WIDTH-1:0]  req_wdata_i,
    output logic [WIDTH-1:0]  rsp_rdata_o,
    output logic              rsp_illegal_o,
    output logic              rsp_virtual_o,
    output logic              stip_o,
    output logic              vstip_o
);

    verdict_t   verdict;
    logic [WIDTH-1:0] time_eff [NUM_CMP];
    logic [WIDTH-1:0] cmp_val  [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_we;
    logic [NUM_CMP-1:0] cmp_pend;

    tcmp_access #(
        .ADDR_W (ADDR_W),
        .S_ADDR (S_ADDR),
        .VS_ADDR(VS_ADDR)
    ) u_access (
        .clk    (clk),
        .rst    (rst),
        .valid  (req_valid_i),
        .addr   (req_addr_i),
        .priv   (priv_i),
        .virt   (virt_i),
        .mtm    (mcnt_tm_i),
        .htm    (hcnt_tm_i),
        .verdict(verdict)
    );

    assign time_eff[IDX_SUP]  = time_i;
    assign time_eff[IDX_VIRT] = time_i + htimedelta_i;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam tgt_e MY_TGT = (g == IDX_SUP) ? TGT_SUP : TGT_VIRT;
        assign cmp_we[g] = req_valid_i && req_write_i && (verdict.tgt == MY_TGT);
        tcmp_cmp_reg #(.WIDTH(WIDTH)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .we      (cmp_we[g]),
            .wdata   (req_wdata_i),
            .time_eff(time_eff[g]),
            .value   (cmp_val[g]),
            .pending (cmp_pend[g])
        );
    end

    always_comb begin
        case (verdict.tgt)
            TGT_SUP:  rsp_rdata_o = cmp_val[IDX_SUP];
            TGT_VIRT: rsp_rdata_o = cmp_val[IDX_VIRT];
            default:  rsp_rdata_o = '0;
        endcase
    end

    assign rsp_illegal_o = verdict.illegal;
    assign rsp_virtual_o = verdict.virt_fault;
    assign stip_o        = cmp_pend[IDX_SUP];
    assign vstip_o       = cmp_pend[IDX_VIRT];

    // R9: faulting request returns no data
    a_r9_fault_zero_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_illegal_o || rsp_virtual_o) |-> (rsp_rdata_o == '0));

    // R9: faulting request leaves both registers alone
    a_r9_fault_no_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && (rsp_illegal_o || rsp_virtual_o)) |=>
            ($stable(cmp_val[IDX_SUP]) && $stable(cmp_val[IDX_VIRT])));

    // R5: machine gate closed blocks every lower level
    a_r5_mgate_illegal: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !mcnt_tm_i && priv_i != 2'd3 &&
         (req_addr_i == ADDR_W'(S_ADDR) || req_addr_i == ADDR_W'(VS_ADDR)))
            |-> rsp_illegal_o);

    // R10: other addresses never fault
    a_r10_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_addr_i != ADDR_W'(S_ADDR) && req_addr_i != ADDR_W'(VS_ADDR))
            |-> !(rsp_illegal_o || rsp_virtual_o));

endmodule

// File: tb/tcmp_top_bench.sv
module tcmp_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] AS = 12'h14D;
    localparam logic [11:0] AV = 12'h24D;
    localparam logic [63:0] ONES = '1;

    typedef struct packed {
        logic [1:0]  priv;
        logic        virt;
        logic        mtm;
        logic        htm;
        logic [11:0] addr;
        logic [1:0]  tgt;   // 0 none, 1 sup, 2 virt
        logic        ill;
        logic        vf;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, AS,       2'd1, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b0, AV,       2'd2, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b1, 1'b0, AS,       2'd1, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b0, 1'b1, AS,       2'd0, 1'b1, 1'b0},
        '{2'd1, 1'b0, 1'b1, 1'b0, AV,       2'd2, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b0, 1'b1, AV,       2'd0, 1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b1, AS,       2'd2, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b0, AS,       2'd0, 1'b0, 1'b1},
        '{2'd1, 1'b1, 1'b0, 1'b1, AS,       2'd0, 1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b1, AV,       2'd0, 1'b0, 1'b1},
        '{2'd1, 1'b1, 1'b0, 1'b1, AV,       2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b0, 1'b1, 1'b1, AS,       2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b0, 1'b1, 1'b1, AV,       2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b1, 1'b1, AS,       2'd0, 1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b0, 1'b1, AS,       2'd0, 1'b1, 1'b0},
        '{2'd2, 1'b0, 1'b1, 1'b1, AS,       2'd0, 1'b1, 1'b0},
        '{2'd3, 1'b1, 1'b0, 1'b0, AS,       2'd1, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b1, 1'b1, 12'h100,  2'd0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_i = '0, htimedelta_i = '0;
    logic [1:0]  priv_i = 2'd3;
    logic        virt_i = 1'b0, mcnt_tm_i = 1'b0, hcnt_tm_i = 1'b0;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [11:0] req_addr_i = '0;
    logic [63:0] req_wdata_i = '0;
    logic [63:0] rsp_rdata_o;
    logic        rsp_illegal_o, rsp_virtual_o, stip_o, vstip_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] s_model, v_model;
    logic [63:0] rd;
    logic        ill, vf;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_top u_tcmp_top (
        .clk(clk), .rst(rst), .time_i(time_i), .htimedelta_i(htimedelta_i),
        .priv_i(priv_i), .virt_i(virt_i), .mcnt_tm_i(mcnt_tm_i),
        .hcnt_tm_i(hcnt_tm_i), .req_valid_i(req_valid_i),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .rsp_rdata_o(rsp_rdata_o),
        .rsp_illegal_o(rsp_illegal_o), .rsp_virtual_o(rsp_virtual_o),
        .stip_o(stip_o), .vstip_o(vstip_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, capture combinational response, let one posedge pass.
    task automatic access(input logic [1:0] p, input logic v, input logic m,
                          input logic h, input logic [11:0] a, input logic w,
                          input logic [63:0] d);
        @(negedge clk);
        priv_i = p; virt_i = v; mcnt_tm_i = m; hcnt_tm_i = h;
        req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_wdata_i = d;
        #1;
        rd = rsp_rdata_o; ill = rsp_illegal_o; vf = rsp_virtual_o;
        @(posedge clk);
        #1;
        req_valid_i = 1'b0; req_write_i = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        settle();
        check("R1 stip after reset", {63'd0, stip_o}, 64'd0);
        check("R1 vstip after reset", {63'd0, vstip_o}, 64'd0);
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b0, 64'd0);
        check("R1 sup reset value", rd, ONES);
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b0, 64'd0);
        check("R1 virt reset value", rd, ONES);

        // load distinct values for the decode table
        s_model = 64'h1111_2222_3333_4444;
        v_model = 64'h5555_6666_7777_8888;
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b1, s_model);
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b1, v_model);

        for (int i = 0; i < NVEC; i++) begin
            logic [63:0] exp_rd;
            access(VECS[i].priv, VECS[i].virt, VECS[i].mtm, VECS[i].htm,
                   VECS[i].addr, 1'b0, 64'd0);
            exp_rd = (VECS[i].tgt == 2'd1) ? s_model :
                     (VECS[i].tgt == 2'd2) ? v_model : 64'd0;
            check($sformatf("R4 R5 R6 R7 R8 R10 vec %0d illegal", i), {63'd0, ill}, {63'd0, VECS[i].ill});
            check($sformatf("R4 R5 R6 R7 R8 R10 vec %0d virtual", i), {63'd0, vf}, {63'd0, VECS[i].vf});
            check($sformatf("R4 R6 R7 R9 vec %0d rdata", i), rd, exp_rd);
        end

        // R2 supervisor pending
        time_i = 64'd100;
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b1, 64'd100);
        settle();
        check("R2 equal raises stip", {63'd0, stip_o}, 64'd1);
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b1, 64'd101);
        settle();
        check("R2 above clears stip", {63'd0, stip_o}, 64'd0);
        time_i = 64'd101;
        #1;
        check("R2 time catches up", {63'd0, stip_o}, 64'd1);
        time_i = 64'h7FFF_FFFF_FFFF_FFFF;
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b1, 64'h8000_0000_0000_0000);
        settle();
        check("R2 unsigned compare", {63'd0, stip_o}, 64'd0);
        s_model = 64'h8000_0000_0000_0000;

        // R3 virtual pending with offset
        time_i = 64'd40; htimedelta_i = 64'd10;
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b1, 64'd50);
        settle();
        check("R3 sum equal raises vstip", {63'd0, vstip_o}, 64'd1);
        htimedelta_i = 64'd9;
        #1;
        check("R3 sum below clears vstip", {63'd0, vstip_o}, 64'd0);
        time_i = 64'hFFFF_FFFF_FFFF_FFF0; htimedelta_i = 64'h20;
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b1, 64'h20);
        settle();
        check("R3 wrapped sum below", {63'd0, vstip_o}, 64'd0);
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b1, 64'h10);
        settle();
        check("R3 wrapped sum equal", {63'd0, vstip_o}, 64'd1);
        v_model = 64'h10;

        // R7 redirected write from virtualized supervisor
        access(2'd1, 1'b1, 1'b1, 1'b1, AS, 1'b1, 64'hABCD);
        check("R7 redirected write no fault", {62'd0, ill, vf}, 64'd0);
        v_model = 64'hABCD;
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b0, 64'd0);
        check("R7 virt register written", rd, v_model);
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b0, 64'd0);
        check("R7 sup register untouched", rd, s_model);

        // R9 faulting writes
        access(2'd1, 1'b1, 1'b1, 1'b0, AS, 1'b1, 64'd5);
        check("R9 virtual fault on write", {63'd0, vf}, 64'd1);
        access(2'd1, 1'b0, 1'b0, 1'b1, AS, 1'b1, 64'd6);
        check("R9 illegal fault on write", {63'd0, ill}, 64'd1);
        access(2'd0, 1'b1, 1'b1, 1'b1, AV, 1'b1, 64'd7);
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b0, 64'd0);
        check("R9 virt register kept", rd, v_model);
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b0, 64'd0);
        check("R9 sup register kept", rd, s_model);

        // R10 other address
        access(2'd3, 1'b0, 1'b1, 1'b1, 12'h14C, 1'b1, 64'd9);
        check("R10 miss no fault", {62'd0, ill, vf}, 64'd0);
        check("R10 miss zero data", rd, 64'd0);
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b0, 64'd0);
        check("R10 sup register kept", rd, s_model);
        access(2'd3, 1'b0, 1'b0, 1'b0, AV, 1'b0, 64'd0);
        check("R10 virt register kept", rd, v_model);

        // R1 reset again restores all ones
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        access(2'd3, 1'b0, 1'b0, 1'b0, AS, 1'b0, 64'd0);
        check("R1 reset restores sup", rd, ONES);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule